// File: doc/BRIEF.md
# SPI Clock-Control Register Slave

This block is a serial slave that exposes a small bank of byte-wide clock-control and identification registers. An external SPI master opens a transaction by pulling chip select low, sends one command byte, then one start-address byte, and then any number of data bytes. Each data byte is either written to the current register or filled from it, and the register address steps up by one after every byte until chip select rises.

The registers drive live control fields straight to the clock generator: a PLL enable, a DCO enable, a PLL bypass, two 3-bit output dividers (phase 0 and phase 90), a 5-bit feedback divider and a 3-bit mask that routes trap, core clock and user clock onto monitor pins. Four read-only bytes return a fixed chip identifier.

A local processor reaches the same registers through a parallel back-door port. That port has a combinational read and a write that takes effect on the clock edge. All serial inputs are resampled into the block clock, so the serial clock must run several times slower than `clk`.

Top module: `hk_spi_regbank`

## Requirements
- R1: After reset, register 0x08 reads 0x02 (`pll_en`=0, `dco_en`=1), 0x09 reads 0x01 (`pll_bypass`=1), 0x11 reads 0x04 (`div_ph0`=4, `div_ph90`=0), 0x12 reads 0x12 and 0x1B reads 0x00.
- R2: MOSI is sampled on rising SCK edges, MSB first (SPI mode 0). In the first byte of a transaction, bit 7 set enables writing (0x80) and bit 6 set enables reading (0x40). The second byte is the start address. A command with neither bit set changes no register.
- R3: In write mode the data bytes go to the start address, then to the start address plus 1, plus 2, and so on, for as long as chip select stays low.
- R4: In read mode `spi_miso` shifts out the register at the start address plus n during data byte n, MSB first, changing after falling SCK edges. `spi_miso` is 0 whenever chip select is high.
- R5: Register 0x08: bit 0 is `pll_en` and bit 1 is `dco_en`. Register 0x09: bit 0 is `pll_bypass`. Unused bits read 0.
- R6: Register 0x11: bits 2:0 are `div_ph0` and bits 5:3 are `div_ph90`. Register 0x12: bits 4:0 are `fb_div`. Unused bits read 0.
- R7: Register 0x1B drives `clk_redirect`: bit 0 routes trap, bit 1 routes the core clock and bit 2 routes the user clock. Bits 7:3 read 0.
- R8: Addresses 0x04 to 0x07 read 0x00, 0x04, 0x56 and 0x11 (identifier 0x00045611, high byte first) and ignore writes from either port. Every other unmapped address reads 0x00 and ignores writes.
- R9: Chip select rising at any point drops a partial byte without a write, and the next transaction starts again with a command byte.
- R10: `bd_rdata` returns the register at `bd_addr` combinationally. A cycle with `bd_we` high writes `bd_wdata` at the next clock edge.
- R11: When an SPI byte write and a back-door write reach the same register in the same cycle, the SPI data is kept. Writes in the same cycle to different registers both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| bd_addr | input | 8 | Back-door register address |
| bd_wdata | input | 8 | Back-door write data |
| bd_we | input | 1 | Back-door write strobe |
| bd_rdata | output | 8 | Back-door read data |
| pll_en | output | 1 | PLL enable |
| dco_en | output | 1 | DCO enable |
| pll_bypass | output | 1 | PLL bypass |
| div_ph0 | output | 3 | Phase-0 output divider |
| div_ph90 | output | 3 | Phase-90 output divider |
| fb_div | output | 5 | Feedback divider |
| clk_redirect | output | 3 | Monitor routing mask (trap, core clock, user clock) |

## Verification
Every register receives a one-byte write whose value has ones in its unused bits. This separates correct field placement from field masking on readback. Multi-byte write and read streams that start below the PLL registers and cross from the identifier bytes into the PLL enables show whether the address steps once per byte. A transaction cut off mid-byte, and a command with neither mode bit, show that nothing is written when the frame is incomplete or has no mode. Back-door writes timed onto the exact cycle of an SPI write, first to the same register and then to a different one, tell SPI priority apart from lost writes.

// File: rtl/hkr_pkg.sv
package hkr_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int BIT_W  = $clog2(DATA_W);

  // register addresses: decoded by the clock generator's software
  localparam logic [ADDR_W-1:0] A_PLLEN = 8'h08;
  localparam logic [ADDR_W-1:0] A_BYP   = 8'h09;
  localparam logic [ADDR_W-1:0] A_SRC   = 8'h11;
  localparam logic [ADDR_W-1:0] A_FB    = 8'h12;
  localparam logic [ADDR_W-1:0] A_REDIR = 8'h1B;

  localparam logic [31:0] CHIP_ID = 32'h0004_5611;

  // command byte mode bits
  localparam int CMD_WR_BIT = 7;
  localparam int CMD_RD_BIT = 6;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA} phase_t;

  typedef struct packed {
    logic       pll_en;
    logic       dco_en;
    logic       bypass;
    logic [2:0] div0;
    logic [2:0] div90;
    logic [4:0] fbdiv;
    logic [2:0] redir;
  } clkctl_t;

  function automatic clkctl_t cfg_reset();
    clkctl_t c;
    c.pll_en = 1'b0;
    c.dco_en = 1'b1;
    c.bypass = 1'b1;
    c.div0   = 3'd4;
    c.div90  = 3'd0;
    c.fbdiv  = 5'h12;
    c.redir  = 3'd0;
    return c;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // identifier byte, high byte at the lowest address
  function automatic logic [DATA_W-1:0] id_byte(input logic [1:0] idx);
    logic [DATA_W-1:0] r;
    case (idx)
      2'd0:    r = CHIP_ID[31:24];
      2'd1:    r = CHIP_ID[23:16];
      2'd2:    r = CHIP_ID[15:8];
      default: r = CHIP_ID[7:0];
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] read_map(input logic [ADDR_W-1:0] a,
                                                  input clkctl_t c);
    logic [DATA_W-1:0] r;
    r = '0;
    case (a)
      8'h04, 8'h05, 8'h06, 8'h07: r = id_byte(a[1:0]);
      A_PLLEN: r = {6'd0, c.dco_en, c.pll_en};
      A_BYP:   r = {7'd0, c.bypass};
      A_SRC:   r = {2'd0, c.div90, c.div0};
      A_FB:    r = {3'd0, c.fbdiv};
      A_REDIR: r = {5'd0, c.redir};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic clkctl_t apply_write(input clkctl_t c,
                                          input logic [ADDR_W-1:0] a,
                                          input logic [DATA_W-1:0] d);
    clkctl_t n;
    n = c;
    case (a)
      A_PLLEN: begin n.pll_en = d[0]; n.dco_en = d[1]; end
      A_BYP:   n.bypass = d[0];
      A_SRC:   begin n.div0 = d[2:0]; n.div90 = d[5:3]; end
      A_FB:    n.fbdiv = d[4:0];
      A_REDIR: n.redir = d[2:0];
      default: ;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/hkr_sync.sv
module hkr_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
      end
    end
  endgenerate

  assign q = chain[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/hkr_spi_frame.sv
module hkr_spi_frame
  import hkr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso
);

  phase_t             phase;
  logic               sck_d;
  logic [BIT_W-1:0]   bit_cnt;
  logic [DATA_W-2:0]  rx;
  logic [DATA_W-1:0]  rx_byte;
  logic [DATA_W-1:0]  tx;
  logic [ADDR_W-1:0]  addr;
  logic               mode_wr;
  logic               mode_rd;
  logic               sck_rise;
  logic               sck_fall;
  logic               byte_done;

  assign sck_rise  = sck_s & ~sck_d & ~csn_s;
  assign sck_fall  = ~sck_s & sck_d & ~csn_s;
  assign rx_byte   = {rx, mosi_s};
  assign byte_done = sck_rise && (bit_cnt == BIT_W'(DATA_W - 1));

  assign wr_fire = byte_done && (phase == PH_DATA) && mode_wr;
  assign wr_addr = addr;
  assign wr_data = rx_byte;

  // address whose contents load the shifter at the end of the current byte
  assign rd_addr = (phase == PH_ADDR) ? rx_byte : addr_inc(addr);

  assign miso = mode_rd & tx[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      phase   <= PH_CMD;
      bit_cnt <= '0;
      rx      <= '0;
      tx      <= '0;
      addr    <= '0;
      mode_wr <= 1'b0;
      mode_rd <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (csn_s) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
        tx      <= '0;
        mode_wr <= 1'b0;
        mode_rd <= 1'b0;
      end else begin
        if (sck_rise) begin
          bit_cnt <= bit_cnt + BIT_W'(1);
          rx      <= rx_byte[DATA_W-2:0];
        end
        if (byte_done) begin
          case (phase)
            PH_CMD: begin
              mode_wr <= rx_byte[CMD_WR_BIT];
              mode_rd <= rx_byte[CMD_RD_BIT];
              phase   <= PH_ADDR;
            end
            PH_ADDR: begin
              addr  <= rx_byte;
              tx    <= rd_data;
              phase <= PH_DATA;
            end
            default: begin
              addr <= addr_inc(addr);
              tx   <= rd_data;
            end
          endcase
        end else if (sck_fall && (bit_cnt != '0)) begin
          tx <= {tx[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/hkr_regfile.sv
module hkr_regfile
  import hkr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bd_addr,
  input  logic [DATA_W-1:0] bd_wdata,
  input  logic              bd_we,
  input  logic              spi_we,
  input  logic [ADDR_W-1:0] spi_waddr,
  input  logic [DATA_W-1:0] spi_wdata,
  input  logic [ADDR_W-1:0] spi_raddr,
  output logic [DATA_W-1:0] spi_rdata,
  output logic [DATA_W-1:0] bd_rdata,
  output clkctl_t           cfg
);

  clkctl_t cfg_next;

  // back-door applied first, SPI second: SPI data survives a collision
  always_comb begin
    cfg_next = cfg;
    if (bd_we)  cfg_next = apply_write(cfg_next, bd_addr, bd_wdata);
    if (spi_we) cfg_next = apply_write(cfg_next, spi_waddr, spi_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= cfg_reset();
    else        cfg <= cfg_next;
  end

  assign bd_rdata  = read_map(bd_addr, cfg);
  assign spi_rdata = read_map(spi_raddr, cfg);

endmodule

// File: rtl/hk_spi_regbank.sv
module hk_spi_regbank
  import hkr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_csn,
  input  logic        spi_mosi,
  output logic        spi_miso,
  input  logic [7:0]  bd_addr,
  input  logic [7:0]  bd_wdata,
  input  logic        bd_we,
  output logic [7:0]  bd_rdata,
  output logic        pll_en,
  output logic        dco_en,
  output logic        pll_bypass,
  output logic [2:0]  div_ph0,
  output logic [2:0]  div_ph90,
  output logic [4:0]  fb_div,
  output logic [2:0]  clk_redirect
);

  logic [2:0]        pins_sync;
  logic              csn_sync;
  logic              sck_sync;
  logic              mosi_sync;
  logic              spi_wr_fire;
  logic [ADDR_W-1:0] spi_wr_addr;
  logic [DATA_W-1:0] spi_wr_data;
  logic [ADDR_W-1:0] spi_rd_addr;
  logic [DATA_W-1:0] spi_rd_data;
  clkctl_t           cfg;

  hkr_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_csn, spi_sck, spi_mosi}),
    .q     (pins_sync)
  );

  assign csn_sync  = pins_sync[2];
  assign sck_sync  = pins_sync[1];
  assign mosi_sync = pins_sync[0];

  hkr_spi_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_s   (sck_sync),
    .csn_s   (csn_sync),
    .mosi_s  (mosi_sync),
    .rd_data (spi_rd_data),
    .rd_addr (spi_rd_addr),
    .wr_fire (spi_wr_fire),
    .wr_addr (spi_wr_addr),
    .wr_data (spi_wr_data),
    .miso    (spi_miso)
  );

  hkr_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bd_addr   (bd_addr),
    .bd_wdata  (bd_wdata),
    .bd_we     (bd_we),
    .spi_we    (spi_wr_fire),
    .spi_waddr (spi_wr_addr),
    .spi_wdata (spi_wr_data),
    .spi_raddr (spi_rd_addr),
    .spi_rdata (spi_rd_data),
    .bd_rdata  (bd_rdata),
    .cfg       (cfg)
  );

  assign pll_en       = cfg.pll_en;
  assign dco_en       = cfg.dco_en;
  assign pll_bypass   = cfg.bypass;
  assign div_ph0      = cfg.div0;
  assign div_ph90     = cfg.div90;
  assign fb_div       = cfg.fbdiv;
  assign clk_redirect = cfg.redir;

endmodule

// File: rtl/hkr_checker.sv
module hkr_checker
  import hkr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       csn_sync,
  input logic       spi_wr_fire,
  input logic [7:0] spi_wr_addr,
  input logic [4:0] spi_fb_data,
  input logic       bd_we,
  input logic [7:0] bd_addr,
  input logic       bd_wbit0,
  input logic       spi_miso,
  input logic       pll_en,
  input logic       dco_en,
  input logic       pll_bypass,
  input logic [2:0] div_ph0,
  input logic [2:0] div_ph90,
  input logic [4:0] fb_div,
  input logic [2:0] clk_redirect
);

  logic       have_prev;
  logic [7:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (csn_sync) begin
      have_prev <= 1'b0;
    end else if (spi_wr_fire) begin
      have_prev <= 1'b1;
      prev_addr <= spi_wr_addr;
    end
  end

  assert_reset_defaults_R1: assert property (@(posedge clk)
    !rst_n |=> (!pll_en && dco_en && pll_bypass && div_ph0 == 3'd4 &&
                div_ph90 == 3'd0 && fb_div == 5'h12 && clk_redirect == 3'd0));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_wr_fire && have_prev) |-> spi_wr_addr == prev_addr + 8'd1);

  assert_miso_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    csn_sync |-> !spi_miso);

  assert_abort_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csn_sync |=> !spi_wr_fire);

  assert_bd_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bd_we && bd_addr == A_BYP && !(spi_wr_fire && spi_wr_addr == A_BYP))
    |=> pll_bypass == $past(bd_wbit0));

  assert_spi_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_wr_fire && bd_we && spi_wr_addr == A_FB && bd_addr == A_FB)
    |=> fb_div == $past(spi_fb_data));

endmodule

bind hk_spi_regbank hkr_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csn_sync     (csn_sync),
  .spi_wr_fire  (spi_wr_fire),
  .spi_wr_addr  (spi_wr_addr),
  .spi_fb_data  (spi_wr_data[4:0]),
  .bd_we        (bd_we),
  .bd_addr      (bd_addr),
  .bd_wbit0     (bd_wdata[0]),
  .spi_miso     (spi_miso),
  .pll_en       (pll_en),
  .dco_en       (dco_en),
  .pll_bypass   (pll_bypass),
  .div_ph0      (div_ph0),
  .div_ph90     (div_ph90),
  .fb_div       (fb_div),
  .clk_redirect (clk_redirect)
);

// File: tb/sim_hk_spi_regbank.sv
module sim_hk_spi_regbank;

  localparam int H = 6;   // SCK half period in clk cycles

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       csn = 1'b1;
  logic       mosi = 1'b0;
  logic       miso;
  logic [7:0] bd_addr = '0;
  logic [7:0] bd_wdata = '0;
  logic       bd_we = 1'b0;
  logic [7:0] bd_rdata;
  logic       pll_en, dco_en, pll_bypass;
  logic [2:0] div_ph0, div_ph90, clk_redirect;
  logic [4:0] fb_div;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  bit         clash_en = 1'b0;
  logic [7:0] clash_addr = '0;
  logic [7:0] clash_data = '0;

  always #5 clk = ~clk;

  hk_spi_regbank u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .bd_addr(bd_addr), .bd_wdata(bd_wdata), .bd_we(bd_we),
    .bd_rdata(bd_rdata), .pll_en(pll_en), .dco_en(dco_en),
    .pll_bypass(pll_bypass), .div_ph0(div_ph0), .div_ph90(div_ph90),
    .fb_div(fb_div), .clk_redirect(clk_redirect)
  );

  // {address, byte written over SPI, expected readback, requirement index}
  localparam logic [31:0] VEC [7] = '{
    {8'h08, 8'hFF, 8'h03, 8'd5},  // R5 unused bits masked
    {8'h09, 8'h00, 8'h00, 8'd5},  // R5 bypass cleared
    {8'h11, 8'h2B, 8'h2B, 8'd6},  // R6 div0=3 div90=5
    {8'h12, 8'hE3, 8'h03, 8'd6},  // R6 feedback masked
    {8'h1B, 8'hFE, 8'h06, 8'd7},  // R7 redirect mask
    {8'h06, 8'hAA, 8'h56, 8'd8},  // R8 id byte read-only
    {8'h40, 8'h55, 8'h00, 8'd8}   // R8 unmapped
  };

  function automatic string req_name(input int n);
    case (n)
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; mosi = tx[i];
      wait_cyc(H);
      rx[i] = miso;
      sck = 1'b1;
      if (clash_en && i == 0) begin
        wait_cyc(2);              // rise seen after two sync stages
        bd_addr = clash_addr; bd_wdata = clash_data; bd_we = 1'b1;
        wait_cyc(1);
        bd_we = 1'b0;
        wait_cyc(H - 3);
      end else begin
        wait_cyc(H);
      end
    end
  endtask

  task automatic cs_begin();
    csn = 1'b0;
    wait_cyc(H);
  endtask

  task automatic cs_end();
    sck = 1'b0;
    wait_cyc(H);
    csn = 1'b1;
    wait_cyc(H);
  endtask

  task automatic spi_write1(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] junk;
    cs_begin();
    spi_byte(8'h80, junk);
    spi_byte(a, junk);
    spi_byte(d, junk);
    cs_end();
  endtask

  task automatic spi_read1(input logic [7:0] a, output logic [7:0] d);
    logic [7:0] junk;
    cs_begin();
    spi_byte(8'h40, junk);
    spi_byte(a, junk);
    spi_byte(8'h00, d);
    cs_end();
  endtask

  task automatic bd_read(input logic [7:0] a, output logic [7:0] d);
    bd_addr = a;
    wait_cyc(1);
    d = bd_rdata;
  endtask

  task automatic bd_write(input logic [7:0] a, input logic [7:0] d);
    bd_addr = a; bd_wdata = d; bd_we = 1'b1;
    wait_cyc(1);
    bd_we = 1'b0;
    wait_cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] junk;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset values
    check("R1", "pll_en", pll_en, 0);
    check("R1", "dco_en", dco_en, 1);
    check("R1", "pll_bypass", pll_bypass, 1);
    check("R1", "div_ph0", div_ph0, 4);
    check("R1", "div_ph90", div_ph90, 0);
    check("R1", "fb_div", fb_div, 5'h12);
    check("R1", "clk_redirect", clk_redirect, 0);
    bd_read(8'h08, r); check("R1", "rd 0x08", r, 8'h02);
    bd_read(8'h11, r); check("R1", "rd 0x11", r, 8'h04);
    bd_read(8'h12, r); check("R1", "rd 0x12", r, 8'h12);
    check("R4", "miso idle", miso, 0);

    // table walk: single-byte SPI writes, read back both ways
    for (int k = 0; k < 7; k++) begin
      spi_write1(VEC[k][31:24], VEC[k][23:16]);
      bd_read(VEC[k][31:24], r);
      check(req_name(int'(VEC[k][7:0])), "backdoor readback", r, VEC[k][15:8]);
      spi_read1(VEC[k][31:24], r);
      check(req_name(int'(VEC[k][7:0])), "spi readback", r, VEC[k][15:8]);
    end
    check("R5", "pll_en", pll_en, 1);
    check("R5", "dco_en", dco_en, 1);
    check("R5", "pll_bypass", pll_bypass, 0);
    check("R6", "div_ph0", div_ph0, 3);
    check("R6", "div_ph90", div_ph90, 5);
    check("R6", "fb_div", fb_div, 3);
    check("R7", "clk_redirect", clk_redirect, 6);

    // R3 stream write with auto-increment
    cs_begin();
    spi_byte(8'h80, junk); spi_byte(8'h11, junk);
    spi_byte(8'h1A, junk); spi_byte(8'h0F, junk);
    cs_end();
    check("R3", "div_ph0", div_ph0, 2);
    check("R3", "div_ph90", div_ph90, 3);
    check("R3", "fb_div", fb_div, 5'h0F);

    // R4 R8 stream read from id into PLL enables
    cs_begin();
    spi_byte(8'h40, junk); spi_byte(8'h04, junk);
    spi_byte(8'h00, r); check("R8", "id byte 0", r, 8'h00);
    spi_byte(8'h00, r); check("R8", "id byte 1", r, 8'h04);
    spi_byte(8'h00, r); check("R8", "id byte 2", r, 8'h56);
    spi_byte(8'h00, r); check("R8", "id byte 3", r, 8'h11);
    spi_byte(8'h00, r); check("R4", "stream into 0x08", r, 8'h03);
    cs_end();
    check("R4", "miso after cs", miso, 0);

    // R9 abort mid-byte: bypass stays 0
    cs_begin();
    spi_byte(8'h80, junk); spi_byte(8'h09, junk);
    for (int i = 0; i < 4; i++) begin
      sck = 1'b0; mosi = 1'b1; wait_cyc(H);
      sck = 1'b1; wait_cyc(H);
    end
    cs_end();
    check("R9", "bypass after abort", pll_bypass, 0);
    spi_write1(8'h09, 8'h01);
    check("R9", "bypass after fresh frame", pll_bypass, 1);

    // R2 command with no mode bit writes nothing
    cs_begin();
    spi_byte(8'h00, junk); spi_byte(8'h09, junk); spi_byte(8'h00, junk);
    cs_end();
    check("R2", "no-mode command", pll_bypass, 1);

    // R10 back-door writes
    bd_write(8'h1B, 8'h05);
    check("R10", "redirect via back-door", clk_redirect, 5);
    bd_read(8'h1B, r); check("R10", "back-door read", r, 8'h05);
    bd_write(8'h05, 8'hFF);
    bd_read(8'h05, r); check("R8", "id write ignored", r, 8'h04);

    // R11 collision on the same register
    clash_en = 1'b1; clash_addr = 8'h12; clash_data = 8'h19;
    spi_write1(8'h12, 8'h07);
    clash_en = 1'b0;
    check("R11", "spi wins fb_div", fb_div, 5'h07);
    // R11 same cycle, different registers
    clash_en = 1'b1; clash_addr = 8'h1B; clash_data = 8'h02;
    spi_write1(8'h12, 8'h08);
    clash_en = 1'b0;
    check("R11", "spi fb_div kept", fb_div, 5'h08);
    check("R11", "back-door redirect kept", clk_redirect, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule